// File: doc/BRIEF.md
# Serial Channel Buffer and Status Tracker

This block keeps the single holding register that sits in front of one serial channel's shift register, and the status flags that describe it. The processor writes transmit words into the holding register and reads received words out of it. The shift-register side reports four kinds of event as pulses: a transfer has started, the holding register has been copied into the shifter, a received word is ready, and a transfer has finished. Parity and framing faults found on the line also arrive as pulses. The checks that produce them happen outside this block.

From these pulses the block keeps a busy flag and a buffer-full flag. It also keeps three sticky error flags: overrun, parity and framing. All five are packed into a 16-bit status word, and bits with no flag read as zero. The buffer-full flag clears differently in each direction. In transmit mode it clears when the shifter takes the word. In receive mode it clears when the processor reads the word. A channel start/stop trigger clears busy and buffer-full. A build parameter removes the three error flags for a cut-down channel variant.

Top module: `sbuf_status`

## Requirements
- R1: After reset the status word is 0000H. Status bits 15:7, 4 and 3 always read 0.
- R2: Busy (status bit 6) is set the cycle after `sh_start` and cleared the cycle after `sh_done`. If both pulse in the same cycle, busy ends up 1.
- R3: With `tx_en`=1, a `cpu_wr` stores `cpu_wdata` into `buf_data` and sets buffer-full (status bit 5). With `tx_en`=1, `sh_load_done` clears buffer-full. A `cpu_wr` with `tx_en`=0 changes neither `buf_data` nor the status.
- R4: With `rx_en`=1, `rx_ready` stores `rx_data` into `buf_data` and sets buffer-full. With `rx_en`=1, `cpu_rd` clears buffer-full.
- R5: With `rx_en`=1, a `par_err` or `frm_err` pulse sets buffer-full.
- R6: A store (R3 or R4) while buffer-full is 1 and nothing drains it in that cycle overwrites `buf_data` and sets overrun (status bit 0). A transmit store and a receive store in the same cycle keep the received word and set overrun.
- R7: With `rx_en`=1, `par_err` sets the parity flag (status bit 1) and `frm_err` sets the framing flag (status bit 2).
- R8: The error flags stay set until `err_clr` pulses with the matching bit of `err_clr_mask` at 1. Mask bit 0 clears overrun, bit 1 clears parity and bit 2 clears framing. A set in the same cycle as a clear wins.
- R9: `chan_trig` clears busy and buffer-full the next cycle, whatever else happens in that cycle. It leaves the error flags and `buf_data` alone.
- R10: When buffer-full gets a set and a drain in the same cycle, it ends up 1. No overrun is raised in that case.
- R11: With `HAS_ERR`=0, status bits 2:0 always read 0. Busy and buffer-full behave as in R2–R5 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit mode enable |
| rx_en | input | 1 | Receive mode enable |
| cpu_wr | input | 1 | Processor write strobe to the holding register |
| cpu_wdata | input | DW | Processor write data |
| cpu_rd | input | 1 | Processor read strobe of the holding register |
| rx_ready | input | 1 | Shifter has a received word |
| rx_data | input | DW | Received word |
| chan_trig | input | 1 | Channel start/stop trigger |
| sh_start | input | 1 | Shifter began a transfer |
| sh_load_done | input | 1 | Shifter copied the holding register |
| sh_done | input | 1 | Shifter finished a transfer |
| par_err | input | 1 | Parity fault pulse |
| frm_err | input | 1 | Framing fault pulse |
| err_clr | input | 1 | Error flag clear strobe |
| err_clr_mask | input | 3 | Per-flag clear mask (0 overrun, 1 parity, 2 framing) |
| status | output | 16 | Packed status word |
| buf_data | output | DW | Holding register content |

## Verification
The collision that matters most is a processor write arriving in the same cycle that the shifter drains the full holding register. Here the set must win and no overrun may appear. The bench drives this case directly with `cpu_wr` and `sh_load_done` in one cycle while the buffer is full. It also drives the receive-side twin, a `cpu_rd` together with `rx_ready`. Random phases make these pairs, and trigger-against-set collisions, occur often. A bench model built from the requirements judges every cycle.

// File: rtl/sbst_pkg.sv
package sbst_pkg;
  localparam int STAT_W   = 16;
  localparam int ERR_N    = 3;
  localparam int BIT_OVR  = 0;
  localparam int BIT_PAR  = 1;
  localparam int BIT_FRM  = 2;
  localparam int BIT_FULL = 5;
  localparam int BIT_BUSY = 6;

  typedef struct packed {
    logic busy;
    logic full;
    logic [ERR_N-1:0] err;
  } sbst_flags_t;
endpackage

// File: rtl/sbst_busy.sv
module sbst_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q, busy_d, busy_en;

  always_comb begin
    busy_en = trig_i | start_i | done_i;
    if (trig_i)       busy_d = 1'b0;
    else if (start_i) busy_d = 1'b1;
    else              busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sbst_buffer.sv
module sbst_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en_i,
  input  logic          rx_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          rx_ready_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          load_done_i,
  input  logic          rx_err_i,
  input  logic          trig_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          ovr_ev_o
);
  logic          full_q, full_d, full_en;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic          tx_store, rx_store, drain, set_full;

  always_comb begin
    tx_store = wr_i & tx_en_i;
    rx_store = rx_ready_i & rx_en_i;
    drain    = (tx_en_i & load_done_i) | (rx_en_i & rd_i);
    set_full = tx_store | rx_store | rx_err_i;

    full_en = trig_i | set_full | drain;
    if (trig_i)        full_d = 1'b0;
    else if (set_full) full_d = 1'b1;
    else               full_d = 1'b0;

    data_en = tx_store | rx_store;
    data_d  = rx_store ? rx_data_i : wdata_i;

    ovr_ev_o = (tx_store & rx_store) |
               ((tx_store | rx_store) & full_q & ~drain);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (full_en) full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/sbst_errflags.sv
module sbst_errflags
  import sbst_pkg::*;
#(
  parameter bit HAS_ERR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] set_i,
  input  logic             clr_i,
  input  logic [ERR_N-1:0] mask_i,
  output logic [ERR_N-1:0] flags_o
);
  generate
    if (HAS_ERR) begin : g_err
      for (genvar i = 0; i < ERR_N; i++) begin : g_bit
        logic flag_q, flag_d, flag_en;
        always_comb begin
          flag_en = set_i[i] | (clr_i & mask_i[i]);
          flag_d  = set_i[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       flag_q <= 1'b0;
          else if (flag_en) flag_q <= flag_d;
        end
        assign flags_o[i] = flag_q;
      end
    end else begin : g_noerr
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, set_i, clr_i, mask_i};
      assign flags_o = '0;
    end
  endgenerate
endmodule

// File: rtl/sbuf_status.sv
module sbuf_status
  import sbst_pkg::*;
#(
  parameter int DW      = 8,
  parameter bit HAS_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              chan_trig,
  input  logic              sh_start,
  input  logic              sh_load_done,
  input  logic              sh_done,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              err_clr,
  input  logic [ERR_N-1:0]  err_clr_mask,
  output logic [STAT_W-1:0] status,
  output logic [DW-1:0]     buf_data
);
  sbst_flags_t      flags;
  logic             ovr_ev, rx_err_ev;
  logic [ERR_N-1:0] err_set;

  assign rx_err_ev = rx_en & (par_err | frm_err);

  always_comb begin
    err_set          = '0;
    err_set[BIT_OVR] = ovr_ev;
    err_set[BIT_PAR] = rx_en & par_err;
    err_set[BIT_FRM] = rx_en & frm_err;
  end

  sbst_busy u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (chan_trig),
    .start_i (sh_start),
    .done_i  (sh_done),
    .busy_o  (flags.busy)
  );

  sbst_buffer #(.DW(DW)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en),
    .rx_en_i     (rx_en),
    .wr_i        (cpu_wr),
    .wdata_i     (cpu_wdata),
    .rd_i        (cpu_rd),
    .rx_ready_i  (rx_ready),
    .rx_data_i   (rx_data),
    .load_done_i (sh_load_done),
    .rx_err_i    (rx_err_ev),
    .trig_i      (chan_trig),
    .full_o      (flags.full),
    .data_o      (buf_data),
    .ovr_ev_o    (ovr_ev)
  );

  sbst_errflags #(.HAS_ERR(HAS_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (err_set),
    .clr_i   (err_clr),
    .mask_i  (err_clr_mask),
    .flags_o (flags.err)
  );

  always_comb begin
    status             = '0;
    status[BIT_BUSY]   = flags.busy;
    status[BIT_FULL]   = flags.full;
    status[ERR_N-1:0]  = flags.err;
  end
endmodule

// File: rtl/sbuf_status_chk.sv
module sbuf_status_chk #(
  parameter int DW      = 8,
  parameter bit HAS_ERR = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          rx_en,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          chan_trig,
  input logic          sh_start,
  input logic          sh_load_done,
  input logic          sh_done,
  input logic          err_clr,
  input logic [2:0]    err_clr_mask,
  input logic [15:0]   status,
  input logic [DW-1:0] buf_data
);
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start && !chan_trig |=> status[6]); // R2
  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done && !sh_start && !chan_trig |=> !status[6]); // R2
  AST_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && cpu_wr && !chan_trig |=> status[5]); // R3
  AST_RX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_ready && !chan_trig |=> status[5] && buf_data == $past(rx_data)); // R4
  AST_OVERRUN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_ERR && tx_en && cpu_wr && status[5] && !(tx_en && sh_load_done)
      && !(rx_en && cpu_rd) |=> status[0]); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !(err_clr && err_clr_mask[0]) |=> status[0]); // R8
  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_trig |=> !status[6] && !status[5]); // R9
  AST_NO_ERR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_ERR |-> status[2:0] == 3'b000); // R11
endmodule

bind sbuf_status sbuf_status_chk #(.DW(DW), .HAS_ERR(HAS_ERR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .rx_ready     (rx_ready),
  .rx_data      (rx_data),
  .chan_trig    (chan_trig),
  .sh_start     (sh_start),
  .sh_load_done (sh_load_done),
  .sh_done      (sh_done),
  .err_clr      (err_clr),
  .err_clr_mask (err_clr_mask),
  .status       (status),
  .buf_data     (buf_data)
);

// File: tb/sbuf_status_bench.sv
`timescale 1ns/1ps
module sbuf_status_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en, rx_en, cpu_wr, cpu_rd, rx_ready, chan_trig;
  logic sh_start, sh_load_done, sh_done, par_err, frm_err, err_clr;
  logic [2:0]    err_clr_mask;
  logic [DW-1:0] cpu_wdata, rx_data;
  logic [15:0]   status, status_ne;
  logic [DW-1:0] buf_data, buf_data_ne;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic          m_busy, m_full;
  logic [DW-1:0] m_data;
  logic [2:0]    m_err;

  always #10 clk = ~clk;

  sbuf_status #(.DW(DW), .HAS_ERR(1'b1)) u_sbuf_status (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .rx_ready(rx_ready), .rx_data(rx_data), .chan_trig(chan_trig),
    .sh_start(sh_start), .sh_load_done(sh_load_done), .sh_done(sh_done),
    .par_err(par_err), .frm_err(frm_err), .err_clr(err_clr),
    .err_clr_mask(err_clr_mask), .status(status), .buf_data(buf_data));

  sbuf_status #(.DW(DW), .HAS_ERR(1'b0)) u_sbuf_status_noerr (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .rx_ready(rx_ready), .rx_data(rx_data), .chan_trig(chan_trig),
    .sh_start(sh_start), .sh_load_done(sh_load_done), .sh_done(sh_done),
    .par_err(par_err), .frm_err(frm_err), .err_clr(err_clr),
    .err_clr_mask(err_clr_mask), .status(status_ne), .buf_data(buf_data_ne));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] exp_status(logic b, logic f, logic [2:0] e);
    return {9'b0, b, f, 2'b00, e};
  endfunction

  task automatic idle();
    cpu_wr = 0; cpu_rd = 0; rx_ready = 0; chan_trig = 0; sh_start = 0;
    sh_load_done = 0; sh_done = 0; par_err = 0; frm_err = 0; err_clr = 0;
    err_clr_mask = 3'b000;
  endtask

  task automatic model_step();
    logic wr_s, rx_s, drain, rx_bad, ovr;
    wr_s   = cpu_wr & tx_en;
    rx_s   = rx_ready & rx_en;
    drain  = (tx_en & sh_load_done) | (rx_en & cpu_rd);
    rx_bad = rx_en & (par_err | frm_err);
    ovr    = (wr_s & rx_s) | ((wr_s | rx_s) & m_full & ~drain);
    m_busy = chan_trig ? 1'b0 : sh_start ? 1'b1 : sh_done ? 1'b0 : m_busy;
    m_full = chan_trig ? 1'b0 : (wr_s | rx_s | rx_bad) ? 1'b1 : drain ? 1'b0 : m_full;
    m_data = rx_s ? rx_data : wr_s ? cpu_wdata : m_data;
    m_err  = {rx_en & frm_err, rx_en & par_err, ovr} |
             (m_err & ~(err_clr ? err_clr_mask : 3'b000));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R2 busy", {31'b0, status[6]}, {31'b0, m_busy});
    check("R3 full", {31'b0, status[5]}, {31'b0, m_full});
    check("R4 data", {24'b0, buf_data}, {24'b0, m_data});
    check("R6 overrun", {31'b0, status[0]}, {31'b0, m_err[0]});
    check("R7 par/frm", {30'b0, status[2:1]}, {30'b0, m_err[2:1]});
    check("R1 spare bits", {16'b0, status & 16'hFF98}, 32'h0);
    check("R11 no-error variant", {16'b0, status_ne}, {16'b0, exp_status(m_busy, m_full, 3'b000)});
    idle();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    rst_n = 0; tx_en = 0; rx_en = 0; cpu_wdata = '0; rx_data = '0;
    idle();
    m_busy = 0; m_full = 0; m_data = '0; m_err = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", {16'b0, status}, 32'h0);
    check("R1 reset status no-error variant", {16'b0, status_ne}, 32'h0);

    // R3 transmit store and drain
    tx_en = 1; cpu_wr = 1; cpu_wdata = 8'hA5; tick();
    check("R3 full after tx write", {31'b0, status[5]}, 1);
    cpu_wr = 1; cpu_wdata = 8'h5A; tick();
    check("R6 overrun on write while full", {31'b0, status[0]}, 1);
    check("R6 new data kept", {24'b0, buf_data}, 32'h5A);
    sh_load_done = 1; tick();
    check("R3 drained by load", {31'b0, status[5]}, 0);
    err_clr = 1; err_clr_mask = 3'b001; tick();
    check("R8 overrun cleared by mask", {31'b0, status[0]}, 0);
    tx_en = 0; cpu_wr = 1; cpu_wdata = 8'hFF; tick();
    check("R3 write ignored without tx_en", {16'b0, status}, 32'h0);
    check("R3 data untouched", {24'b0, buf_data}, 32'h5A);

    // R10 set against drain while full
    tx_en = 1; cpu_wr = 1; cpu_wdata = 8'h11; tick();
    cpu_wr = 1; cpu_wdata = 8'h22; sh_load_done = 1; tick();
    check("R10 full stays set", {31'b0, status[5]}, 1);
    check("R10 no overrun", {31'b0, status[0]}, 0);
    sh_load_done = 1; tick(); tx_en = 0;

    // R4 receive path, R5 and R7 errors
    rx_en = 1; rx_ready = 1; rx_data = 8'h3C; tick();
    check("R4 receive stores", {24'b0, buf_data}, 32'h3C);
    cpu_rd = 1; rx_ready = 1; rx_data = 8'h4D; tick();
    check("R10 read with new word keeps full", {31'b0, status[5]}, 1);
    check("R6 read with new word no overrun", {31'b0, status[0]}, 0);
    cpu_rd = 1; tick();
    check("R4 read clears full", {31'b0, status[5]}, 0);
    par_err = 1; tick();
    check("R5 R7 parity sets flag and full", {16'b0, status & 16'h0027}, 32'h0022);
    check("R11 variant ignores parity", {16'b0, status_ne}, 32'h0020);
    cpu_rd = 1; tick();
    frm_err = 1; err_clr = 1; err_clr_mask = 3'b110; tick();
    check("R8 framing set wins, parity cleared", {29'b0, status[2:0]}, 32'h4);

    // R2 busy and R9 trigger
    sh_start = 1; tick();
    check("R2 busy set", {31'b0, status[6]}, 1);
    sh_start = 1; sh_done = 1; tick();
    check("R2 start wins over done", {31'b0, status[6]}, 1);
    sh_done = 1; tick();
    check("R2 busy cleared", {31'b0, status[6]}, 0);
    sh_start = 1; tick();
    rx_ready = 1; rx_data = 8'h77; chan_trig = 1; tick();
    check("R9 trigger clears busy and full", {30'b0, status[6:5]}, 0);
    check("R9 errors kept", {29'b0, status[2:0]}, 32'h5);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) begin
        tx_en = 1'($urandom); rx_en = 1'($urandom);
      end
      cpu_wr       = ($urandom_range(3) == 0);
      cpu_rd       = ($urandom_range(3) == 0);
      rx_ready     = ($urandom_range(3) == 0);
      sh_load_done = ($urandom_range(3) == 0);
      sh_start     = ($urandom_range(4) == 0);
      sh_done      = ($urandom_range(4) == 0);
      chan_trig    = ($urandom_range(31) == 0);
      par_err      = ($urandom_range(15) == 0);
      frm_err      = ($urandom_range(15) == 0);
      err_clr      = ($urandom_range(7) == 0);
      err_clr_mask = 3'($urandom);
      cpu_wdata    = 8'($urandom);
      rx_data      = 8'($urandom);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule